// File: doc/BRIEF.md
# Adapter Control Register with Software-Driven Bus Handshake

This block is a 16-bit control and status register that a host reads and writes to manage a network adapter. It reports the speed-strap pins as a link-rate code. It shows the live transfer direction and the bus-request line. It also holds the bits that reset the adapter, halt its embedded processor, choose RAM or ROM for the boot region and raise local-bus priority for an external bus master. Each of these bits drives an output to the rest of the adapter.

The register also supports a software-driven DMA mode. When that mode is on, the host emulates the bus-grant handshake by writing an acknowledge bit, and the hardware grant input is ignored. The request bit follows the bus-mode select: it reads the request line as is in active-high mode and inverted in active-low mode. From the enable, acknowledge and request bits the block decodes an interrupt that asks the host to start a transfer.

A clock-fault input forces the adapter-reset bit to 1. The register port keeps working while the adapter is held in reset, so the host can still read and write it.

Top module: `adp_ctl_reg`

## Requirements
- R1: `rd_data[2:0]` shows `strap[2:0]`. `link_rate` is 2'b00 (reserved) when `strap[2]` is 0. When `strap[2]` is 1, it is 2'b01 (16 Mbit/s) if `strap[0]` is 0 and 2'b10 (4 Mbit/s) if `strap[0]` is 1. `strap[1]` has no effect.
- R2: Bit 3 and bits 15:12 always read 0. Host writes to the read-only bits 0–3, 5, 6 and 12–15 change no register.
- R3: Bit 7 is the software-DMA enable. The acknowledge bit (bit 4) takes the written value only when the same write also sets bit 7. Otherwise it becomes 0, and it never reads 1 while bit 7 is 0.
- R4: `bus_grant` equals `hw_grant` while bit 7 is 0. It equals bit 4 while bit 7 is 1, and `hw_grant` is then ignored.
- R5: `pdma_irq` is 1 exactly when bit 7 is 1, bit 4 is 0 and bit 6 is 1.
- R6: While `clk_fault` is 1, bit 8 is set on each clock edge. A host write that clears bit 8 in the same cycle loses to the fault.
- R7: Bit 5 shows `dir_line` (0 = host to adapter, 1 = adapter to host).
- R8: Bit 6 equals `req_line` when `req_active_high` is 1 and its inverse when `req_active_high` is 0.
- R9: After reset, bits 8 and 9 are 1 and bits 4, 7, 10 and 11 are 0.
- R10: Bits 8, 9, 10 and 11 can be written, and they drive `adapter_rst`, `cpu_halt`, `boot_ram` and `lbus_prio` in that order. Bit 7 drives `pdma_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Register read value |
| strap | input | 3 | Speed configuration strap pins |
| req_line | input | 1 | Live bus-request line |
| dir_line | input | 1 | Live transfer-direction line |
| req_active_high | input | 1 | Bus mode: 1 = request read as is, 0 = inverted |
| hw_grant | input | 1 | Hardware hold-acknowledge input |
| clk_fault | input | 1 | Clock-failure indication |
| link_rate | output | 2 | Decoded strap speed code |
| adapter_rst | output | 1 | Holds adapter in reset |
| cpu_halt | output | 1 | Halts processor bus access |
| boot_ram | output | 1 | Boot region is RAM (1) or ROM (0) |
| lbus_prio | output | 1 | Local-bus priority for external master |
| pdma_on | output | 1 | Software DMA mode enabled |
| bus_grant | output | 1 | Effective bus grant |
| pdma_irq | output | 1 | Software DMA request interrupt |

## Verification
The block has no parameters, so the bench builds its single configuration, and every input combination is small enough to enumerate. The bench sweeps all 64 combinations of the strap, direction, request and bus-mode inputs against an arithmetic model of the read value and the link-rate decode. It then writes all 64 combinations of the six writable bits, with every read-only bit set in the write data, and checks the read value, the grant with the hardware grant at 0 and at 1, and the interrupt. Directed steps cover the reset values and a clock fault that arrives in the same cycle as a write clearing the reset bit.

// File: rtl/adp_ctl_reg.sv
module adp_ctl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic [2:0]  strap,
  input  logic        req_line,
  input  logic        dir_line,
  input  logic        req_active_high,
  input  logic        hw_grant,
  input  logic        clk_fault,
  output logic [1:0]  link_rate,
  output logic        adapter_rst,
  output logic        cpu_halt,
  output logic        boot_ram,
  output logic        lbus_prio,
  output logic        pdma_on,
  output logic        bus_grant,
  output logic        pdma_irq
);

  logic en_q, ack_q, rst_q, halt_q, boot_q, prio_q;
  logic req_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ack_q  <= 1'b0;
      rst_q  <= 1'b1;
      halt_q <= 1'b1;
      boot_q <= 1'b0;
      prio_q <= 1'b0;
    end else begin
      if (wr_en) begin
        en_q   <= wr_data[7];
        ack_q  <= wr_data[7] & wr_data[4];
        halt_q <= wr_data[9];
        boot_q <= wr_data[10];
        prio_q <= wr_data[11];
      end
      if (clk_fault)
        rst_q <= 1'b1;
      else if (wr_en)
        rst_q <= wr_data[8];
    end
  end

  assign req_view  = req_active_high ? req_line : ~req_line;

  assign link_rate = !strap[2] ? 2'b00 : (strap[0] ? 2'b10 : 2'b01);

  assign rd_data = {4'b0000, prio_q, boot_q, halt_q, rst_q,
                    en_q, req_view, dir_line, ack_q, 1'b0, strap};

  assign adapter_rst = rst_q;
  assign cpu_halt    = halt_q;
  assign boot_ram    = boot_q;
  assign lbus_prio   = prio_q;
  assign pdma_on     = en_q;
  assign bus_grant   = en_q ? ack_q : hw_grant;
  assign pdma_irq    = en_q & ~ack_q & req_view;

endmodule

module adp_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic        clk_fault,
  input logic        adapter_rst,
  input logic        pdma_on,
  input logic        bus_grant,
  input logic        pdma_irq
);

  always_comb begin
    assert_rsvd_zero_R2: assert (rd_data[3] == 1'b0 && rd_data[15:12] == 4'b0000);
  end

  assert_ack_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4] |-> rd_data[7]);

  assert_grant_sw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pdma_on |-> (bus_grant == rd_data[4]));

  assert_irq_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pdma_irq |-> (rd_data[7] && !rd_data[4] && rd_data[6]));

  assert_fault_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fault |=> adapter_rst);

endmodule

bind adp_ctl_reg adp_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .clk_fault(clk_fault),
  .adapter_rst(adapter_rst), .pdma_on(pdma_on), .bus_grant(bus_grant),
  .pdma_irq(pdma_irq)
);

// File: tb/adp_ctl_reg_test.sv
module adp_ctl_reg_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0] strap = 3'b100;
  logic req_line = 0, dir_line = 0, req_active_high = 1, hw_grant = 0, clk_fault = 0;
  logic [1:0] link_rate;
  logic adapter_rst, cpu_halt, boot_ram, lbus_prio, pdma_on, bus_grant, pdma_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adp_ctl_reg uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] model(input logic [5:0] c, input logic [2:0] s,
                                        input logic d, input logic r, input logic m);
    logic en, ack, rq;
    en  = c[1];
    ack = c[0] & c[1];
    rq  = m ? r : ~r;
    return {4'b0, c[5], c[4], c[3], c[2], en, rq, d, ack, 1'b0, s};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [5:0] cfg;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset", rd_data & 16'h0F90, 16'h0300);
    chk("R10 reset outputs", {12'b0, adapter_rst, cpu_halt, boot_ram, lbus_prio}, 16'h000C);

    wr(16'h0000);
    cfg = 6'b000000;
    for (int i = 0; i < 64; i++) begin
      strap = i[2:0]; dir_line = i[3]; req_line = i[4]; req_active_high = i[5];
      #1;
      // R1 R7 R8: readback and decode
      chk("R1 R7 R8 status", rd_data, model(cfg, i[2:0], i[3], i[4], i[5]));
      e = {14'b0, (!i[2]) ? 2'b00 : (i[0] ? 2'b10 : 2'b01)};
      chk("R1 link rate", {14'b0, link_rate}, e);
    end

    strap = 3'b101; dir_line = 1; req_line = 1; req_active_high = 1;
    for (int p = 0; p < 64; p++) begin
      // bits: p0->4 ack, p1->7 en, p2->8, p3->9, p4->10, p5->11; read-only bits all set (R2)
      wr({4'hF, p[5], p[4], p[3], p[2], p[1], 2'b11, p[0], 4'hF});
      cfg = p[5:0];
      chk("R2 R3 R10 readback", rd_data, model(cfg, 3'b101, 1'b1, 1'b1, 1'b1));
      chk("R10 outputs", {11'b0, pdma_on, adapter_rst, cpu_halt, boot_ram, lbus_prio},
          {11'b0, p[1], p[2], p[3], p[4], p[5]});
      hw_grant = 1; #1;
      chk("R4 grant hw1", {15'b0, bus_grant}, {15'b0, p[1] ? p[0] : 1'b1});
      hw_grant = 0; #1;
      chk("R4 grant hw0", {15'b0, bus_grant}, {15'b0, p[1] & p[0]});
      chk("R5 irq", {15'b0, pdma_irq}, {15'b0, p[1] & ~p[0]});
    end

    // R5: irq follows request polarity and clears on ack
    wr(16'h0080);
    req_active_high = 0; req_line = 1; #1;
    chk("R5 irq inverted mode idle", {15'b0, pdma_irq}, 16'h0);
    req_line = 0; #1;
    chk("R5 irq inverted mode req", {15'b0, pdma_irq}, 16'h1);
    wr(16'h0090);
    chk("R5 irq cleared by ack", {15'b0, pdma_irq}, 16'h0);

    // R6: fault wins over a write clearing bit 8
    wr(16'h0000);
    chk("R6 cleared by write", {15'b0, adapter_rst}, 16'h0);
    @(negedge clk); wr_en = 1; wr_data = 16'h0000; clk_fault = 1;
    @(negedge clk); wr_en = 0; clk_fault = 0;
    chk("R6 fault beats write", {15'b0, rd_data[8]}, 16'h1);
    wr(16'h0000);
    @(negedge clk); clk_fault = 1;
    @(negedge clk); clk_fault = 0;
    chk("R6 fault alone", {15'b0, adapter_rst}, 16'h1);

    finish_run();
  end
endmodule